// File: doc/BRIEF.md
# Slave Arbiter with Default-Master Parking

This block decides which of several bus masters owns one slave port. Masters hold a request bit high while they want the slave. The current owner pulses an end-of-transfer strobe on the last beat of its single access or burst. A new owner is chosen only at that boundary. When several masters compete, the choice rotates round-robin, starting after the master that was served last. The grant moves straight to the next owner, with no idle cycle between transfers.

When nobody wants the slave, the arbiter can leave the grant parked on a default master. That master's next first beat then starts in the same cycle as its request, instead of waiting one arbitration cycle. A per-slave setting selects the parking policy: no parking, park on the most recent user, or park on a fixed master index. The block has three states. ARB_IDLE means no grant. ARB_PARK means a grant was pre-issued by parking. ARB_BUSY means a master owns the slave for an access in progress.

The transitions are:
- T_GRANT: ARB_IDLE or ARB_PARK to ARB_BUSY, when a request wins arbitration.
- T_PARK: any state to ARB_PARK, when no request is pending and a default master exists.
- T_RELEASE: to ARB_IDLE, when no request is pending and there is no default master.
- T_HIT: ARB_PARK to ARB_BUSY, when the parked master requests.
- T_HOLD: stay in ARB_BUSY until the end-of-transfer strobe.
- T_HANDOFF: ARB_BUSY to ARB_BUSY with a new owner, when others wait at a boundary.

Top module: `slv_park_arb`

## Requirements
- R1: At most one bit of `mst_gnt` is high. `park_gnt` is high only while some grant bit is high.
- R2: After reset, `mst_gnt` is all zero, `park_gnt` is 0, and the block behaves as under policy 2'b00.
- R3: Under `cfg_mode` 2'b00 (no parking) or 2'b11 (reserved, treated the same way), the cycle after an access ends with no other request, `mst_gnt` is all zero. A request seen while idle is granted at the next clock edge.
- R4: Under `cfg_mode` 2'b01, when an access ends with no other request, the grant stays on that access's master, and `park_gnt` goes to 1 the next cycle.
- R5: Under `cfg_mode` 2'b10, the idle slave parks on master `cfg_fixed_idx`. An index of N_MST or more means no parking.
- R6: A parked master that raises its request finds its grant already high in that same cycle. `park_gnt` drops the next cycle. If the strobe comes in that same cycle, the access is complete.
- R7: While the slave is parked, a request from a different master moves the grant to that master at the next clock edge.
- R8: While an access is in progress (strobe low), the grant does not change, whatever the other requests do.
- R9: When the strobe comes and other masters request, the next cycle grants the first requester after the finishing owner in rising circular index order. No idle cycle is inserted.
- R10: While the slave is idle or parked with no request, a change of `cfg_mode` or `cfg_fixed_idx` moves the grant to the new target one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mst_req | input | N_MST | Request bit per master |
| xfer_end | input | 1 | Last beat of the owner's current access |
| cfg_mode | input | 2 | Parking policy: 00 none, 01 last user, 10 fixed, 11 none |
| cfg_fixed_idx | input | IW | Parked master for policy 10 |
| mst_gnt | output | N_MST | One-hot grant |
| park_gnt | output | 1 | Grant is pre-issued by parking |

## Verification
The key collision is a parked master raising its request in the same cycle that it ends a single-beat access. In that one cycle, the park hit and the end-of-transfer decision both apply. The bench provokes this under the fixed policy by driving the request and the strobe together while parked. It then expects the grant to stay parked on the fixed master, with `park_gnt` still high. A second collision is the strobe arriving while several masters wait. There the handoff must skip the finishing owner and leave no gap cycle.

// File: rtl/slv_park_pkg.sv
package slv_park_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_PARK = 2'd1,
        ARB_BUSY = 2'd2
    } arb_state_t;

    typedef enum logic [1:0] {
        PARK_NONE  = 2'b00,
        PARK_LAST  = 2'b01,
        PARK_FIXED = 2'b10,
        PARK_RSVD  = 2'b11
    } park_mode_t;

endpackage

// File: rtl/slv_park_rr.sv
// Round-robin picker: first requester after the pointer, circular order.
module slv_park_rr #(
    parameter int N_MST = 5,
    parameter int IW    = 3
) (
    input  logic [N_MST-1:0] req,
    input  logic [IW-1:0]    ptr,
    output logic             pick_vld,
    output logic [IW-1:0]    pick_idx
);

    always_comb begin
        pick_vld = 1'b0;
        pick_idx = '0;
        // Walk from the farthest offset down to the nearest, so the nearest wins.
        for (int off = N_MST; off >= 1; off--) begin
            if (req[(int'(ptr) + off) % N_MST]) begin
                pick_vld = 1'b1;
                pick_idx = IW'((int'(ptr) + off) % N_MST);
            end
        end
    end

endmodule

// File: rtl/slv_park_target.sv
// Works out which master, if any, an idle slave should be parked on.
module slv_park_target
    import slv_park_pkg::*;
#(
    parameter int N_MST = 5,
    parameter int IW    = 3
) (
    input  logic [1:0]    mode,
    input  logic [IW-1:0] fixed_idx,
    input  logic [IW-1:0] last_idx,
    input  logic          last_vld,
    output logic          tgt_vld,
    output logic [IW-1:0] tgt_idx
);

    always_comb begin
        tgt_vld = 1'b0;
        tgt_idx = '0;
        unique case (park_mode_t'(mode))
            PARK_LAST: begin
                tgt_vld = last_vld;
                tgt_idx = last_idx;
            end
            PARK_FIXED: begin
                tgt_vld = (int'(fixed_idx) < N_MST);
                tgt_idx = fixed_idx;
            end
            PARK_NONE, PARK_RSVD: begin
                tgt_vld = 1'b0;
            end
            default: tgt_vld = 1'b0;
        endcase
    end

endmodule

// File: rtl/slv_park_arb.sv
module slv_park_arb
    import slv_park_pkg::*;
#(
    parameter int N_MST = 5,
    localparam int IW   = (N_MST > 1) ? $clog2(N_MST) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MST-1:0] mst_req,
    input  logic             xfer_end,
    input  logic [1:0]       cfg_mode,
    input  logic [IW-1:0]    cfg_fixed_idx,
    output logic [N_MST-1:0] mst_gnt,
    output logic             park_gnt
);

    arb_state_t       st_q, st_d;
    logic [IW-1:0]    own_q, own_d;
    logic [IW-1:0]    lacc_q, lacc_d;
    logic             lvld_q, lvld_d;

    logic [N_MST-1:0] own_hot;
    logic             active;
    logic             decide;
    logic [N_MST-1:0] arb_req;
    logic [IW-1:0]    lst_idx;
    logic             lst_vld;
    logic             rr_vld;
    logic [IW-1:0]    rr_idx;
    logic             tgt_vld;
    logic [IW-1:0]    tgt_idx;

    assign own_hot = N_MST'(1) << own_q;
    // An access is running when busy, or when the parked master uses its grant.
    assign active  = (st_q == ARB_BUSY) || ((st_q == ARB_PARK) && mst_req[own_q]);
    // A boundary, or an idle slave, lets arbitration and parking take effect.
    assign decide  = !active || xfer_end;
    // The finishing owner's own request is the one being retired.
    assign arb_req = active ? (mst_req & ~own_hot) : mst_req;
    assign lst_idx = active ? own_q : lacc_q;
    assign lst_vld = active || lvld_q;

    slv_park_rr #(.N_MST(N_MST), .IW(IW)) u_rr (
        .req      (arb_req),
        .ptr      (lst_idx),
        .pick_vld (rr_vld),
        .pick_idx (rr_idx)
    );

    slv_park_target #(.N_MST(N_MST), .IW(IW)) u_tgt (
        .mode      (cfg_mode),
        .fixed_idx (cfg_fixed_idx),
        .last_idx  (lst_idx),
        .last_vld  (lst_vld),
        .tgt_vld   (tgt_vld),
        .tgt_idx   (tgt_idx)
    );

    // Next-state logic.
    always_comb begin
        st_d   = st_q;
        own_d  = own_q;
        lacc_d = active ? own_q : lacc_q;
        lvld_d = lst_vld;
        unique case (st_q)
            ARB_IDLE, ARB_PARK: begin
                if (decide) begin
                    if (rr_vld) begin             // T_GRANT
                        st_d  = ARB_BUSY;
                        own_d = rr_idx;
                    end else if (tgt_vld) begin   // T_PARK
                        st_d  = ARB_PARK;
                        own_d = tgt_idx;
                    end else begin                // T_RELEASE
                        st_d  = ARB_IDLE;
                    end
                end else begin                    // T_HIT
                    st_d = ARB_BUSY;
                end
            end
            ARB_BUSY: begin
                if (decide) begin
                    if (rr_vld) begin             // T_HANDOFF
                        st_d  = ARB_BUSY;
                        own_d = rr_idx;
                    end else if (tgt_vld) begin   // T_PARK
                        st_d  = ARB_PARK;
                        own_d = tgt_idx;
                    end else begin                // T_RELEASE
                        st_d  = ARB_IDLE;
                    end
                end                               // else T_HOLD
            end
            default: st_d = ARB_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ARB_IDLE;
            own_q  <= '0;
            lacc_q <= '0;
            lvld_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            own_q  <= own_d;
            lacc_q <= lacc_d;
            lvld_q <= lvld_d;
        end
    end

    // Outputs.
    always_comb begin
        mst_gnt  = '0;
        park_gnt = 1'b0;
        unique case (st_q)
            ARB_IDLE: mst_gnt = '0;
            ARB_PARK: begin
                mst_gnt  = own_hot;
                park_gnt = 1'b1;
            end
            ARB_BUSY: mst_gnt = own_hot;
            default:  mst_gnt = '0;
        endcase
    end

endmodule

// File: rtl/slv_park_chk.sv
module slv_park_chk #(
    parameter int N_MST = 5,
    parameter int IW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_MST-1:0] mst_req,
    input logic             xfer_end,
    input logic [1:0]       cfg_mode,
    input logic [IW-1:0]    cfg_fixed_idx,
    input logic [N_MST-1:0] mst_gnt,
    input logic             park_gnt,
    input logic             act,
    input logic [N_MST-1:0] arb_req
);

    logic [N_MST-1:0] fix_hot;
    assign fix_hot = N_MST'(1) << cfg_fixed_idx;

    AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mst_gnt)); // R1

    AST_PARK_HAS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
        park_gnt |-> (mst_gnt != '0)); // R1

    AST_NONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (act && xfer_end && arb_req == '0 && (cfg_mode == 2'b00 || cfg_mode == 2'b11))
        |=> (mst_gnt == '0)); // R3

    AST_FIXED_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (act && xfer_end && arb_req == '0 && cfg_mode == 2'b10 && int'(cfg_fixed_idx) < N_MST)
        |=> (park_gnt && mst_gnt == $past(fix_hot))); // R5

    AST_MOVE_OFF_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (park_gnt && (mst_req & mst_gnt) == '0 && mst_req != '0)
        |=> (!park_gnt && (mst_gnt & $past(mst_req)) != '0)); // R7

    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !xfer_end) |=> $stable(mst_gnt)); // R8

    AST_HANDOFF_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (act && xfer_end && arb_req != '0)
        |=> (!park_gnt && (mst_gnt & $past(arb_req)) != '0)); // R9

endmodule

bind slv_park_arb slv_park_chk #(.N_MST(N_MST), .IW(IW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mst_req       (mst_req),
    .xfer_end      (xfer_end),
    .cfg_mode      (cfg_mode),
    .cfg_fixed_idx (cfg_fixed_idx),
    .mst_gnt       (mst_gnt),
    .park_gnt      (park_gnt),
    .act           (active),
    .arb_req       (arb_req)
);

// File: tb/test_slv_park_arb.sv
module test_slv_park_arb;

    localparam int N = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] mst_req = '0;
    logic         xfer_end = 1'b0;
    logic [1:0]   cfg_mode = 2'b00;
    logic [2:0]   cfg_fixed_idx = '0;
    logic [N-1:0] mst_gnt;
    logic         park_gnt;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [N-1:0] g;
        logic         p;
        string        tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;

    always #2 clk = ~clk;

    slv_park_arb #(.N_MST(N)) i_slv_park_arb (
        .clk           (clk),
        .rst_n         (rst_n),
        .mst_req       (mst_req),
        .xfer_end      (xfer_end),
        .cfg_mode      (cfg_mode),
        .cfg_fixed_idx (cfg_fixed_idx),
        .mst_gnt       (mst_gnt),
        .park_gnt      (park_gnt)
    );

    task automatic compare(input logic [N-1:0] eg, input logic ep, input string tag);
        total++;
        if (mst_gnt !== eg || park_gnt !== ep) begin
            bad++;
            $display("FAIL %s: gnt=%b park=%b expected gnt=%b park=%b",
                     tag, mst_gnt, park_gnt, eg, ep);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the result expected after the edge.
    task automatic step(input logic [N-1:0] r, input logic e, input logic [1:0] ty,
                        input logic [2:0] fx, input logic [N-1:0] eg, input logic ep,
                        input string tag);
        exp_t it;
        @(negedge clk);
        mst_req       = r;
        xfer_end      = e;
        cfg_mode      = ty;
        cfg_fixed_idx = fx;
        it.g   = eg;
        it.p   = ep;
        it.tag = tag;
        exp_q.push_back(it);
    endtask

    // Monitor: pop and compare just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                cur = exp_q.pop_front();
                compare(cur.g, cur.p, cur.tag);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare('0, 1'b0, "R2 reset state");

        // no-default policy
        step(5'b00001, 0, 2'b00, 3'd0, 5'b00001, 0, "R3 grant one cycle after idle request");
        step(5'b00001, 1, 2'b00, 3'd0, 5'b00000, 0, "R3 release after end");
        step(5'b00000, 0, 2'b00, 3'd0, 5'b00000, 0, "R3 stays idle");
        // last-user policy
        step(5'b00100, 0, 2'b01, 3'd0, 5'b00100, 0, "R3 grant master 2");
        step(5'b00100, 1, 2'b01, 3'd0, 5'b00100, 1, "R4 park on last user");
        step(5'b00000, 0, 2'b01, 3'd0, 5'b00100, 1, "R4 remains parked");
        step(5'b00100, 0, 2'b01, 3'd0, 5'b00100, 0, "R6 parked master hit");
        step(5'b00100, 0, 2'b01, 3'd0, 5'b00100, 0, "R8 hold during access");
        step(5'b00110, 0, 2'b01, 3'd0, 5'b00100, 0, "R8 no preemption");
        step(5'b00110, 1, 2'b01, 3'd0, 5'b00010, 0, "R9 handoff no gap");
        step(5'b01011, 1, 2'b01, 3'd0, 5'b01000, 0, "R9 round robin after owner");
        step(5'b00001, 1, 2'b01, 3'd0, 5'b00001, 0, "R9 wrap to master 0");
        step(5'b00000, 1, 2'b01, 3'd0, 5'b00001, 1, "R4 park on master 0");
        step(5'b10000, 0, 2'b01, 3'd0, 5'b10000, 0, "R7 other master takes parked slave");
        // fixed policy
        step(5'b10000, 1, 2'b10, 3'd3, 5'b01000, 1, "R5 park on fixed master 3");
        step(5'b01000, 1, 2'b10, 3'd3, 5'b01000, 1, "R6 hit and end in same cycle");
        step(5'b00000, 0, 2'b10, 3'd6, 5'b00000, 0, "R5 out-of-range index means none");
        step(5'b00000, 0, 2'b10, 3'd1, 5'b00010, 1, "R10 config change moves park");
        step(5'b00000, 0, 2'b11, 3'd1, 5'b00000, 0, "R3 reserved mode acts as none");
        step(5'b00100, 0, 2'b00, 3'd1, 5'b00100, 0, "R3 grant from idle");
        step(5'b00100, 1, 2'b00, 3'd1, 5'b00000, 0, "R3 release under none");
        step(5'b00000, 0, 2'b00, 3'd1, 5'b00000, 0, "R10 idle stays idle");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule